// File: doc/BRIEF.md
# Transition-Detect Auto Standby Controller

This block puts a small logic array to sleep when nothing around it is moving. Each cycle of a free-running sampling clock it compares a monitored vector against its value at the previous edge. The vector is made of the dedicated inputs, the I/O pin values, the clock-pin level and the internal feedback signals. Any bit that differs counts as activity. A counter tracks how many consecutive sample edges have seen no activity. When that count reaches a parameterised threshold, the controller asserts a power-down indication and freezes the outputs at the values they held at that moment.

While the block is asleep, the outputs come from a hold register, so changes on the live output bus do not reach the output port. The first edge that sees any monitored bit change wakes the block. At that edge power-down is released and the live outputs pass through again. The block then stays awake until the monitored signals go quiet for the full threshold once more. The threshold is counted in sampling-clock cycles and defaults to three.

Top module: `idle_standby_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pwr_down` is 0 and `out_q` equals `live_out`. This holds even when the block was asleep before reset.
- R2: A difference in any bit of `in_pins`, `io_pins`, `clk_pin` or `fb_sig`, compared with its value at the previous sample edge, counts as activity.
- R3: Activity clears the quiet counter to zero. This also applies at the edge where the counter would otherwise have reached the threshold, and in that case standby is not entered.
- R4: `pwr_down` goes to 1 at the edge that completes `IDLE_THRESH` consecutive sample edges without activity. The default is 3, so with constant inputs after reset release it rises on the third edge.
- R5: On entry to standby, the hold register keeps the `live_out` value present at the entry edge. While `pwr_down` is 1, `out_q` shows that value whatever `live_out` does.
- R6: The first sample edge that sees activity while asleep clears `pwr_down`, and from that edge `out_q` follows `live_out`.
- R7: If monitored signals change at every sample edge, `pwr_down` stays 0 indefinitely.
- R8: While `pwr_down` is 0, `out_q` equals `live_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pins | input | N_IN | Dedicated input values to watch |
| io_pins | input | N_IO | I/O pin values to watch |
| clk_pin | input | 1 | Level of the array's clock pin, watched as data |
| fb_sig | input | N_FB | Internal feedback signals to watch |
| live_out | input | N_OUT | Output values produced by the logic array |
| out_q | output | N_OUT | Outputs after the standby hold stage |
| pwr_down | output | 1 | High while the block is in standby |

## Verification
The assertions assume that every monitored input is synchronous to `clk` and settles between edges. Under that assumption, a change seen between two edges is the same as a change in the activity flag. The assertions also assume that `live_out` is only meaningful at sample edges. The stimulus changes all inputs one time unit after a rising edge and keeps them constant until the next edge. It never drives an unknown value after reset, so each comparison against the previous sample is well defined.

// File: rtl/tdas_pkg.sv
package tdas_pkg;

    typedef enum logic [0:0] {
        PM_AWAKE  = 1'b0,
        PM_ASLEEP = 1'b1
    } pm_state_e;

    typedef struct packed {
        logic enter;
        logic leave;
    } pm_event_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        int unsigned w;
        w = 1;
        while ((1 << w) <= limit) w++;
        return w;
    endfunction

    function automatic logic [31:0] sat_inc(input logic [31:0] v,
                                            input logic [31:0] lim);
        return (v >= lim) ? lim : v + 32'd1;
    endfunction

endpackage

// File: rtl/tdas_activity_detect.sv
module tdas_activity_detect #(
    parameter int unsigned W     = 9,
    parameter int unsigned LANES = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] mon,
    output logic         activity
);
    localparam int unsigned LANE_W = (W + LANES - 1) / LANES;
    localparam int unsigned PAD_W  = LANE_W * LANES;

    logic [W-1:0]     prev_q;
    logic [PAD_W-1:0] diff_pad;
    logic [LANES-1:0] lane_hit;

    always_ff @(posedge clk) begin
        prev_q <= mon;
    end

    always_comb begin
        diff_pad = '0;
        if (!rst) diff_pad[W-1:0] = mon ^ prev_q;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = |diff_pad[g*LANE_W +: LANE_W];
    end

    assign activity = |lane_hit;

endmodule

// File: rtl/tdas_idle_timer.sv
module tdas_idle_timer
    import tdas_pkg::*;
#(
    parameter int unsigned IDLE_THRESH = 3,
    parameter int unsigned CW          = cnt_width(IDLE_THRESH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          activity,
    output logic [CW-1:0] idle_cnt,
    output logic          near_limit
);
    localparam logic [31:0] LIM32  = 32'(IDLE_THRESH);
    localparam logic [CW-1:0] LAST = CW'(IDLE_THRESH - 1);

    logic [CW-1:0] cnt_next;

    always_comb begin
        if (activity) cnt_next = '0;
        else          cnt_next = CW'(sat_inc(32'(idle_cnt), LIM32));
    end

    always_ff @(posedge clk) begin
        if (rst) idle_cnt <= '0;
        else     idle_cnt <= cnt_next;
    end

    assign near_limit = !activity && (idle_cnt == LAST);

endmodule

// File: rtl/tdas_sleep_fsm.sv
module tdas_sleep_fsm
    import tdas_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      activity,
    input  logic      near_limit,
    output pm_state_e state,
    output pm_event_t evt
);
    pm_state_e state_next;

    always_comb begin
        state_next = state;
        evt        = '0;
        unique case (state)
            PM_AWAKE: begin
                if (near_limit) begin
                    state_next = PM_ASLEEP;
                    evt.enter  = 1'b1;
                end
            end
            PM_ASLEEP: begin
                if (activity) begin
                    state_next = PM_AWAKE;
                    evt.leave  = 1'b1;
                end
            end
            default: state_next = PM_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_AWAKE;
        else     state <= state_next;
    end

endmodule

// File: rtl/tdas_hold_stage.sv
module tdas_hold_stage
    import tdas_pkg::*;
#(
    parameter int unsigned N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  pm_state_e        state,
    input  logic [N_OUT-1:0] live_out,
    output logic [N_OUT-1:0] out_q
);
    logic [N_OUT-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || state == PM_AWAKE) hold_q <= live_out;
    end

    for (genvar b = 0; b < N_OUT; b++) begin : g_bit
        assign out_q[b] = (state == PM_ASLEEP) ? hold_q[b] : live_out[b];
    end

endmodule

// File: rtl/idle_standby_ctrl.sv
module idle_standby_ctrl
    import tdas_pkg::*;
#(
    parameter int unsigned N_IN        = 4,
    parameter int unsigned N_IO        = 2,
    parameter int unsigned N_FB        = 2,
    parameter int unsigned N_OUT       = 4,
    parameter int unsigned IDLE_THRESH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_IO-1:0]  io_pins,
    input  logic             clk_pin,
    input  logic [N_FB-1:0]  fb_sig,
    input  logic [N_OUT-1:0] live_out,
    output logic [N_OUT-1:0] out_q,
    output logic             pwr_down
);
    localparam int unsigned MON_W = N_IN + N_IO + 1 + N_FB;
    localparam int unsigned CW    = cnt_width(IDLE_THRESH);

    logic [MON_W-1:0] mon_vec;
    logic             activity;
    logic [CW-1:0]    idle_cnt;
    logic             near_limit;
    pm_state_e        state;
    pm_event_t        evt;

    assign mon_vec = {fb_sig, clk_pin, io_pins, in_pins};

    tdas_activity_detect #(.W(MON_W), .LANES(3)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .mon      (mon_vec),
        .activity (activity)
    );

    tdas_idle_timer #(.IDLE_THRESH(IDLE_THRESH), .CW(CW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .activity   (activity),
        .idle_cnt   (idle_cnt),
        .near_limit (near_limit)
    );

    tdas_sleep_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .activity   (activity),
        .near_limit (near_limit),
        .state      (state),
        .evt        (evt)
    );

    tdas_hold_stage #(.N_OUT(N_OUT)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .live_out (live_out),
        .out_q    (out_q)
    );

    assign pwr_down = (state == PM_ASLEEP);

endmodule

// File: rtl/idle_standby_ctrl_chk.sv
module idle_standby_ctrl_chk #(
    parameter int unsigned N_IN        = 4,
    parameter int unsigned N_IO        = 2,
    parameter int unsigned N_FB        = 2,
    parameter int unsigned N_OUT       = 4,
    parameter int unsigned IDLE_THRESH = 3,
    parameter int unsigned CW          = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N_IN-1:0]  in_pins,
    input logic [N_IO-1:0]  io_pins,
    input logic             clk_pin,
    input logic [N_FB-1:0]  fb_sig,
    input logic [N_OUT-1:0] live_out,
    input logic [N_OUT-1:0] out_q,
    input logic             pwr_down,
    input logic             activity,
    input logic [CW-1:0]    idle_cnt
);
    // R2
    pin_change_seen_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({fb_sig, clk_pin, io_pins, in_pins}) |-> activity);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        activity |=> (idle_cnt == '0));

    // R4
    sleep_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down) |-> (idle_cnt == CW'(IDLE_THRESH)));

    // R5
    frozen_out_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && $past(pwr_down)) |-> $stable(out_q));

    // R6
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && activity) |=> !pwr_down);

    // R8
    live_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |-> (out_q == live_out));

endmodule

bind idle_standby_ctrl idle_standby_ctrl_chk #(
    .N_IN(N_IN), .N_IO(N_IO), .N_FB(N_FB), .N_OUT(N_OUT),
    .IDLE_THRESH(IDLE_THRESH), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst), .in_pins(in_pins), .io_pins(io_pins),
    .clk_pin(clk_pin), .fb_sig(fb_sig), .live_out(live_out),
    .out_q(out_q), .pwr_down(pwr_down), .activity(activity),
    .idle_cnt(idle_cnt)
);

// File: tb/idle_standby_ctrl_bench.sv
module idle_standby_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_pins = '0;
    logic [1:0] io_pins = '0;
    logic       clk_pin = 1'b0;
    logic [1:0] fb_sig = '0;
    logic [3:0] live_out = 4'h5;
    logic [3:0] out_q;
    logic       pwr_down;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    idle_standby_ctrl u_idle_standby_ctrl (
        .clk(clk), .rst(rst), .in_pins(in_pins), .io_pins(io_pins),
        .clk_pin(clk_pin), .fb_sig(fb_sig), .live_out(live_out),
        .out_q(out_q), .pwr_down(pwr_down)
    );

    // row: in[17:14] io[13:12] cp[11] fb[10:9] live[8:5] pd[4] out[3:0]
    localparam int NV = 17;
    localparam logic [17:0] VEC [NV] = '{
        {4'h0, 2'h0, 1'b0, 2'h0, 4'h5, 1'b0, 4'h5},  // quiet 1
        {4'h0, 2'h0, 1'b0, 2'h0, 4'h5, 1'b0, 4'h5},  // quiet 2
        {4'h0, 2'h0, 1'b0, 2'h0, 4'h5, 1'b1, 4'h5},  // R4 enter
        {4'h0, 2'h0, 1'b0, 2'h0, 4'hA, 1'b1, 4'h5},  // R5 frozen
        {4'h1, 2'h0, 1'b0, 2'h0, 4'hA, 1'b0, 4'hA},  // R6 wake via input
        {4'h1, 2'h0, 1'b0, 2'h0, 4'h3, 1'b0, 4'h3},  // R8 live
        {4'h1, 2'h0, 1'b0, 2'h0, 4'h3, 1'b0, 4'h3},
        {4'h1, 2'h1, 1'b0, 2'h0, 4'h3, 1'b0, 4'h3},  // R3 io change at limit
        {4'h1, 2'h1, 1'b0, 2'h0, 4'h3, 1'b0, 4'h3},
        {4'h1, 2'h1, 1'b0, 2'h0, 4'h3, 1'b0, 4'h3},
        {4'h1, 2'h1, 1'b0, 2'h0, 4'h3, 1'b1, 4'h3},  // R4
        {4'h1, 2'h1, 1'b0, 2'h0, 4'hC, 1'b1, 4'h3},  // R5
        {4'h1, 2'h1, 1'b1, 2'h0, 4'hC, 1'b0, 4'hC},  // R2 clock pin wakes
        {4'h1, 2'h1, 1'b1, 2'h0, 4'hC, 1'b0, 4'hC},
        {4'h1, 2'h1, 1'b1, 2'h0, 4'hC, 1'b0, 4'hC},
        {4'h1, 2'h1, 1'b1, 2'h0, 4'hC, 1'b1, 4'hC},  // R4
        {4'h1, 2'h1, 1'b1, 2'h2, 4'h9, 1'b0, 4'h9}   // R2 feedback wakes
    };

    task automatic check(input string req, input logic [3:0] act_o, input logic [3:0] exp_o,
                         input logic act_p, input logic exp_p);
        n_run++;
        if (act_o !== exp_o || act_p !== exp_p) begin
            n_fail++;
            $display("FAIL %s: out_q=%h pwr_down=%b expected out_q=%h pwr_down=%b",
                     req, act_o, act_p, exp_o, exp_p);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        tick(); tick();
        check("R1", out_q, live_out, pwr_down, 1'b0);
        live_out = 4'h6; #1;
        check("R1", out_q, 4'h6, pwr_down, 1'b0);
        live_out = 4'h5;
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            in_pins  = VEC[i][17:14];
            io_pins  = VEC[i][13:12];
            clk_pin  = VEC[i][11];
            fb_sig   = VEC[i][10:9];
            live_out = VEC[i][8:5];
            tick();
            check($sformatf("R2-R6 table row %0d", i), out_q, VEC[i][3:0], pwr_down, VEC[i][4]);
        end

        // R7 toggling every edge keeps block awake
        for (int i = 0; i < 12; i++) begin
            in_pins[2] = ~in_pins[2];
            live_out   = 4'(i);
            tick();
            check("R7", out_q, 4'(i), pwr_down, 1'b0);
        end

        // go to sleep, then reset: R1
        live_out = 4'hE;
        tick(); tick(); tick();
        check("R4", out_q, 4'hE, pwr_down, 1'b1);
        live_out = 4'h7;
        rst = 1'b1;
        tick();
        check("R1", out_q, 4'h7, pwr_down, 1'b0);
        rst = 1'b0;
        tick();
        check("R1", out_q, 4'h7, pwr_down, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule